// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This unit sits beside each processor's interrupt controller and decides whether an interrupt message on the shared fabric is meant for this processor. Each message carries a destination identifier and a mode bit. In physical mode the identifier names exactly one processor. In logical mode the identifier names a set of processors. The set is read either as a flat bitmask, with one bit for each processor, or as a cluster number plus a member bitmask. A configuration register picks between these two readings.

Software programs three local registers through a small write port: the physical ID, the logical ID and the format selector. For every valid message the unit raises a registered accept flag one cycle later if the message targets this processor. A logical destination can match several processors at the same time. Choosing one of them is left to an arbitration stage further on.

Top module: `irq_dest_matcher`

## Requirements
- R1: After reset the accept output is 0, the physical ID equals the parameter PHYS_ID_RST (default 0x00), the logical ID is 0x00 and the format is flat.
- R2: With msg_logical = 0 (physical mode), a message is accepted only when all 8 bits of msg_dest equal the physical ID. For example, ID 0x13 rejects 0x03 and 0x93.
- R3: In physical mode, destination 0xFF is accepted by every processor, whatever its physical ID.
- R4: With msg_logical = 1 and the format flat, a message is accepted when msg_dest AND the logical ID is nonzero.
- R5: With msg_logical = 1 and the format cluster, a message is accepted when destination bits [7:4] equal logical ID bits [7:4] and the AND of bits [3:0] is nonzero. For example, IDs 0x21, 0x22 and 0x24 accept 0x27, while 0x28 does not.
- R6: In logical mode, destination 0xFF is accepted in either format whenever the logical ID is nonzero. A logical ID of 0x00 never accepts a logical message.
- R7: accept is asserted in the cycle after a valid message that matches. It is 0 in the cycle after any cycle in which msg_valid is low.
- R8: A write with cfg_wr_sel = 0 loads the physical ID, 1 loads the logical ID, 2 loads the format and 3 changes nothing. The new value governs messages from the next cycle on. A message in the same cycle as the write is judged against the old value.
- R9: A format write uses only cfg_wr_data[0], where 0 means flat and 1 means cluster. All other data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Interrupt message present this cycle |
| msg_dest | input | ID_W | Destination identifier of the message |
| msg_logical | input | 1 | 0 = physical mode, 1 = logical mode |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 physical ID, 1 logical ID, 2 format, 3 none |
| cfg_wr_data | input | ID_W | Configuration write data |
| accept | output | 1 | Registered match flag for the previous cycle's message |

## Verification
A configuration write and a message can arrive in the same cycle. This is the one place where two functions meet. The bench provokes it on purpose: it rewrites the physical ID while presenting a message addressed to the new ID, and in the random phase writes and messages collide freely. The bench judges each case against a reference model. That model updates its register copies only after it has computed the expected accept for the cycle, so a message in the write cycle must be matched against the old configuration.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    typedef enum logic {
        FMT_FLAT    = 1'b0,
        FMT_CLUSTER = 1'b1
    } dst_fmt_e;

    typedef enum logic [1:0] {
        SEL_PHYS_ID = 2'd0,
        SEL_LOG_ID  = 2'd1,
        SEL_FORMAT  = 2'd2,
        SEL_NONE    = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic phys_hit;
        logic log_hit;
    } hit_vec_t;

    function automatic logic pick_hit(input hit_vec_t h, input logic logical);
        return logical ? h.log_hit : h.phys_hit;
    endfunction

endpackage

// File: rtl/ldm_cfg_regs.sv
module ldm_cfg_regs
    import ldm_pkg::*;
#(
    parameter int          ID_W        = 8,
    parameter logic [ID_W-1:0] PHYS_ID_RST = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [ID_W-1:0] wr_data,
    output logic [ID_W-1:0] phys_id,
    output logic [ID_W-1:0] log_id,
    output dst_fmt_e        fmt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phys_id <= PHYS_ID_RST;
            log_id  <= '0;
            fmt     <= FMT_FLAT;
        end else if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_PHYS_ID: phys_id <= wr_data;
                SEL_LOG_ID:  log_id  <= wr_data;
                SEL_FORMAT:  fmt     <= dst_fmt_e'(wr_data[0]);
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/ldm_phys_cmp.sv
module ldm_phys_cmp #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] dest,
    input  logic [ID_W-1:0] phys_id,
    output logic            hit
);

    logic exact;
    logic bcast;

    assign exact = (dest == phys_id);
    assign bcast = &dest;
    assign hit   = exact | bcast;

endmodule

// File: rtl/ldm_logic_cmp.sv
module ldm_logic_cmp
    import ldm_pkg::*;
#(
    parameter int ID_W            = 8,
    parameter bit SUPPORT_CLUSTER = 1'b1
) (
    input  logic [ID_W-1:0] dest,
    input  logic [ID_W-1:0] log_id,
    input  dst_fmt_e        fmt,
    output logic            hit
);

    localparam int HALF_W = ID_W / 2;

    logic [ID_W-1:0] overlap;
    logic            flat_hit;
    logic            clus_hit;
    logic            id_live;
    logic            bcast;

    for (genvar gi = 0; gi < ID_W; gi++) begin : g_bit
        assign overlap[gi] = dest[gi] & log_id[gi];
    end

    assign flat_hit = |overlap;
    assign id_live  = |log_id;
    assign bcast    = &dest;

    if (SUPPORT_CLUSTER) begin : g_cluster
        logic same_cluster;
        logic member_hit;
        assign same_cluster = (dest[ID_W-1:HALF_W] == log_id[ID_W-1:HALF_W]);
        assign member_hit   = |overlap[HALF_W-1:0];
        assign clus_hit     = same_cluster & member_hit;
    end else begin : g_flat_only
        assign clus_hit = flat_hit;
    end

    always_comb begin
        if (!id_live)
            hit = 1'b0;
        else if (bcast)
            hit = 1'b1;
        else if (fmt == FMT_CLUSTER)
            hit = clus_hit;
        else
            hit = flat_hit;
    end

endmodule

// File: rtl/irq_dest_matcher.sv
module irq_dest_matcher
    import ldm_pkg::*;
#(
    parameter int              ID_W            = 8,
    parameter logic [ID_W-1:0] PHYS_ID_RST     = '0,
    parameter bit              SUPPORT_CLUSTER = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            msg_valid,
    input  logic [ID_W-1:0] msg_dest,
    input  logic            msg_logical,
    input  logic            cfg_wr_en,
    input  logic [1:0]      cfg_wr_sel,
    input  logic [ID_W-1:0] cfg_wr_data,
    output logic            accept
);

    logic [ID_W-1:0] phys_id_w;
    logic [ID_W-1:0] log_id_w;
    dst_fmt_e        fmt_w;
    logic            fmt_cluster_w;
    hit_vec_t        hits;

    ldm_cfg_regs #(.ID_W(ID_W), .PHYS_ID_RST(PHYS_ID_RST)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .phys_id (phys_id_w),
        .log_id  (log_id_w),
        .fmt     (fmt_w)
    );

    ldm_phys_cmp #(.ID_W(ID_W)) phys_i (
        .dest    (msg_dest),
        .phys_id (phys_id_w),
        .hit     (hits.phys_hit)
    );

    ldm_logic_cmp #(.ID_W(ID_W), .SUPPORT_CLUSTER(SUPPORT_CLUSTER)) logic_i (
        .dest   (msg_dest),
        .log_id (log_id_w),
        .fmt    (fmt_w),
        .hit    (hits.log_hit)
    );

    assign fmt_cluster_w = (fmt_w == FMT_CLUSTER);

    always_ff @(posedge clk) begin
        if (rst)
            accept <= 1'b0;
        else
            accept <= msg_valid & pick_hit(hits, msg_logical);
    end

endmodule

// File: rtl/irq_dest_matcher_chk.sv
module irq_dest_matcher_chk #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            msg_valid,
    input logic [ID_W-1:0] msg_dest,
    input logic            msg_logical,
    input logic            cfg_wr_en,
    input logic [1:0]      cfg_wr_sel,
    input logic [ID_W-1:0] cfg_wr_data,
    input logic            accept,
    input logic [ID_W-1:0] phys_id,
    input logic [ID_W-1:0] log_id,
    input logic            fmt_cluster
);

    localparam int HALF_W = ID_W / 2;

    AST_ACC_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(msg_valid)) else $error("acc without valid"); // R7

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |=> !accept) else $error("acc after idle"); // R7

    AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_logical && (&msg_dest)) |=> accept) else $error("phys bcast"); // R3

    AST_PHYS_MISS: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_logical && !(&msg_dest) && msg_dest != phys_id) |=> !accept)
        else $error("phys miss"); // R2

    AST_LOG_ZERO_ID: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_logical && log_id == '0) |=> !accept) else $error("zero lid"); // R6

    AST_FLAT_HIT: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_logical && !fmt_cluster && (msg_dest & log_id) != '0) |=> accept)
        else $error("flat hit"); // R4

    AST_CLUSTER_MISS: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_logical && fmt_cluster && !(&msg_dest) &&
         msg_dest[ID_W-1:HALF_W] != log_id[ID_W-1:HALF_W]) |=> !accept)
        else $error("cluster miss"); // R5

    AST_LOG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_wr_sel == 2'd1) |=> log_id == $past(cfg_wr_data))
        else $error("lid write"); // R8

    AST_NONE_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && cfg_wr_sel == 2'd3) |=> ($stable(phys_id) && $stable(log_id) && $stable(fmt_cluster)))
        else $error("sel3 write"); // R8

endmodule

bind irq_dest_matcher irq_dest_matcher_chk #(.ID_W(ID_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .msg_valid   (msg_valid),
    .msg_dest    (msg_dest),
    .msg_logical (msg_logical),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_sel  (cfg_wr_sel),
    .cfg_wr_data (cfg_wr_data),
    .accept      (accept),
    .phys_id     (phys_id_w),
    .log_id      (log_id_w),
    .fmt_cluster (fmt_cluster_w)
);

// File: tb/irq_dest_matcher_tb_top.sv
`timescale 1ns/1ps
module irq_dest_matcher_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_dest = '0;
    logic       msg_logical = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_sel = '0;
    logic [7:0] cfg_wr_data = '0;
    logic       accept;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_phys = 0;
    int m_log  = 0;
    bit m_clu  = 0;

    always #2 clk = ~clk;

    irq_dest_matcher dut_i (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_dest(msg_dest),
        .msg_logical(msg_logical), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .accept(accept)
    );

    function automatic bit ref_hit(int d, bit lg);
        if (!lg) return (d == m_phys) || (d == 255);
        if (m_log == 0) return 0;
        if (d == 255) return 1;
        if (!m_clu) return (d & m_log) != 0;
        return ((d / 16) == (m_log / 16)) && (((d % 16) & (m_log % 16)) != 0);
    endfunction

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s accept actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare after the next posedge
    task automatic cyc(string tag, bit v, int d, bit lg, bit we, int sel, int wd);
        bit exp;
        msg_valid = v; msg_dest = 8'(d); msg_logical = lg;
        cfg_wr_en = we; cfg_wr_sel = 2'(sel); cfg_wr_data = 8'(wd);
        exp = v && ref_hit(d, lg);
        if (we) begin
            if (sel == 0) m_phys = wd;
            else if (sel == 1) m_log = wd;
            else if (sel == 2) m_clu = wd[0];
        end
        @(posedge clk); #1;
        check(tag, accept, exp);
        @(negedge clk);
    endtask

    task automatic wr(int sel, int wd);
        cyc("R8", 0, 0, 0, 1, sel, wd);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; check("R1", accept, 1'b0);
        @(negedge clk); rst = 1'b0;
        cyc("R1", 0, 0, 0, 0, 0, 0);
        cyc("R1", 1, 8'h00, 0, 0, 0, 0);   // reset physical ID 0
        cyc("R1", 1, 8'hFF, 1, 0, 0, 0);   // logical ID 0 -> nothing
        // write physical ID with a colliding message: old ID judged
        cyc("R8", 1, 8'h13, 0, 1, 0, 8'h13);
        cyc("R2", 1, 8'h13, 0, 0, 0, 0);
        cyc("R2", 1, 8'h03, 0, 0, 0, 0);
        cyc("R2", 1, 8'h93, 0, 0, 0, 0);
        cyc("R3", 1, 8'hFF, 0, 0, 0, 0);
        // flat logical
        wr(1, 8'h04);
        cyc("R4", 1, 8'h95, 1, 0, 0, 0);
        cyc("R4", 1, 8'h0B, 1, 0, 0, 0);
        cyc("R7", 0, 8'h95, 1, 0, 0, 0);
        cyc("R7", 1, 8'h04, 1, 0, 0, 0);
        // format bit only from data[0]
        wr(1, 8'h21);
        wr(2, 8'hFE);
        cyc("R9", 1, 8'h31, 1, 0, 0, 0);
        wr(2, 8'h01);
        cyc("R5", 1, 8'h31, 1, 0, 0, 0);
        cyc("R5", 1, 8'h27, 1, 0, 0, 0);
        wr(1, 8'h22); cyc("R5", 1, 8'h27, 1, 0, 0, 0);
        wr(1, 8'h24); cyc("R5", 1, 8'h27, 1, 0, 0, 0);
        wr(1, 8'h28); cyc("R5", 1, 8'h27, 1, 0, 0, 0);
        // logical broadcast
        wr(1, 8'h50);
        cyc("R6", 1, 8'hFF, 1, 0, 0, 0);
        cyc("R6", 1, 8'h5F, 1, 0, 0, 0);
        wr(1, 8'h00);
        cyc("R6", 1, 8'hFF, 1, 0, 0, 0);
        // select 3 changes nothing
        wr(1, 8'h41);
        wr(3, 8'hAA);
        cyc("R8", 1, 8'h41, 1, 0, 0, 0);
        cyc("R8", 1, 8'h13, 0, 0, 0, 0);
        cyc("R8", 1, 8'hAA, 0, 0, 0, 0);
        // random mixed traffic with colliding writes
        for (int i = 0; i < 2000; i++) begin
            bit lg = 1'($urandom);
            int d  = (($urandom % 4) == 0) ? 255 : int'($urandom % 256);
            bit we = (($urandom % 5) == 0);
            int sel = int'($urandom % 4);
            int wd  = int'($urandom % 256);
            string tag = !lg ? "R2" : (m_clu ? "R5" : "R4");
            cyc(tag, 1'($urandom % 4 != 0), d, lg, we, sel, wd);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule